// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Bank

This block holds a bank of 8-bit control registers. Software in another device loads them over one of two serial front ends. A static select pin picks the front end. The first is a write-only two-wire target in the I2C style. Its 7-bit device address has a fixed upper part and two low bits taken from pins. The second is a three-wire interface in which an active-low enable line frames each transfer. All serial inputs pass through two synchronizing flip-flops and a two-sample agreement filter before any edge detection.

On the two-wire side, the first byte after the device address is a subaddress. That subaddress picks one of two write styles. A normal subaddress names one register, and exactly one data byte follows it. A subaddress whose five low bits are all ones starts a whole-bank load instead. Each following data byte lands in the next register, counting up from register 0. A global block input freezes the bank against both front ends.

The registers appear in parallel on one flat output bus. Each register also has a one-cycle write strobe.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset, register k holds (16*k + 5) mod 256, every write strobe is low and the acknowledge drive `sda_oe` is low.
- R2: The two-wire target acknowledges only an address byte equal to {1,0,0,1,1,`addr_pins[1]`,`addr_pins[0]`} followed by a R/W bit (bit 0) of 0. Any other address byte, or R/W = 1, is not acknowledged, and nothing from that transaction reaches a register.
- R3: Single mode: a subaddress byte names register `sub[3:0]`, is acknowledged, and is followed by one data byte. That data byte is acknowledged and written. The next byte is again a subaddress. Bits 7..5 of the subaddress are ignored.
- R4: A subaddress with bits 4..0 = 11111 starts bank mode. The data bytes that follow are written to registers 0, 1, 2, ... in that order, each acknowledged. A subaddress with bit 4 set and any other low nibble stays in single mode.
- R5: In bank mode, a data byte arriving after the last register has been written is not acknowledged and changes nothing.
- R6: In single mode, a data byte aimed at an index of 14 or above (no such register) is not acknowledged and changes nothing.
- R7: Three-wire transfer: while `sen_i` is low, a bit is taken from `sdat_i` on each rising `sclk_i`, MSB first. When `sen_i` rises after exactly 16 bits, the first byte's bits 3..0 name the register and the second byte is written. A frame of any other length is discarded.
- R8: `if_sel` = 0 selects the two-wire target and `if_sel` = 1 selects the three-wire port. Traffic on the deselected interface changes no register, and `sda_oe` stays low while `if_sel` = 1.
- R9: While `upd_block` is high, no register changes and no write strobe rises, whichever interface is active.
- R10: Every accepted write raises `wr_stb_o[k]` for exactly one clock, in the cycle the new value first appears. At most one strobe is high at a time, and a register without its strobe keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_sel | input | 1 | 0 = two-wire target, 1 = three-wire port |
| upd_block | input | 1 | High freezes all register updates |
| addr_pins | input | 2 | Low two bits of the device address |
| scl_i | input | 1 | Two-wire serial clock |
| sda_i | input | 1 | Two-wire data line as seen on the pad |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| sen_i | input | 1 | Three-wire enable, active low |
| sclk_i | input | 1 | Three-wire clock |
| sdat_i | input | 1 | Three-wire data |
| regs_o | output | 112 | Register k at bits 8k+7..8k |
| wr_stb_o | output | 14 | Per-register one-cycle write strobe |

## Verification
The bench sweeps every address-pin setting against every value of the two compared address bits and the R/W bit. A target that compared the wrong pin order, or that accepted reads, would acknowledge the wrong cases and corrupt registers. Bank mode is driven one byte past the end of the bank, so an off-by-one pointer would either write a ghost byte or refuse the last register. A mode decode that looked at bit 4 alone would send a single write to register 0. The three-wire side is fed 15- and 17-bit frames, which a design that commits on any enable edge would accept. Blocked and deselected traffic is checked at the register outputs and through strobe counts, where a leaky gate would show up as a changed value or a stray pulse.

// File: rtl/cfg_bank_pkg.sv
`timescale 1ns/1ps
package cfg_bank_pkg;
    localparam int SUB_IDX_W = 4;
    localparam int PTR_W     = SUB_IDX_W + 1;
    localparam logic [4:0] DEV_ADDR_HI = 5'b10011;
    localparam logic [4:0] BANK_CODE   = 5'b11111;

    typedef enum logic [1:0] {TS_IDLE, TS_RECV, TS_ACK} tgt_state_e;
    typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} phase_e;

    typedef struct packed {
        logic             valid;
        logic [PTR_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic [7:0] reg_default(input int k);
        return 8'(((k % 16) * 16) + 5);
    endfunction
endpackage

// File: rtl/cfg_in_sync.sv
`timescale 1ns/1ps
module cfg_in_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;
    logic [W-1:0] prev_d, prev_q, out_d, out_q, last, diff;

    assign last = chain_q[STAGES-1];
    assign diff = last ^ prev_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
        prev_d = last;
        // take a new level only after two consecutive agreeing samples
        out_d  = (~diff & last) | (diff & out_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
            out_q   <= RST_VAL;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
            out_q   <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/cfg_i2c_tgt.sv
`timescale 1ns/1ps
module cfg_i2c_tgt
    import cfg_bank_pkg::*;
#(
    parameter int NUM_REGS = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] addr_pins,
    input  logic       scl,
    input  logic       sda,
    output logic       sda_oe,
    output wr_req_t    wr_o
);
    typedef struct packed {
        tgt_state_e       st;
        phase_e           ph;
        logic             bank;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             drive;
        logic             scl_p;
        logic             sda_p;
        wr_req_t          wr;
    } i2c_q_t;

    localparam i2c_q_t RST = '{st: TS_IDLE, ph: PH_ADDR, bank: 1'b0, cnt: '0,
                               sh: '0, ptr: '0, drive: 1'b0, scl_p: 1'b1,
                               sda_p: 1'b1, wr: '0};
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS);

    i2c_q_t d, q;
    logic   rise, fall, start_c, stop_c, ok_c;

    assign rise    = scl & ~q.scl_p;
    assign fall    = ~scl & q.scl_p;
    assign start_c = scl & q.scl_p & q.sda_p & ~sda;
    assign stop_c  = scl & q.scl_p & ~q.sda_p & sda;

    always_comb begin
        d       = q;
        d.wr    = '0;
        d.scl_p = scl;
        d.sda_p = sda;
        ok_c    = 1'b0;
        if (!en) begin
            d       = RST;
            d.scl_p = scl;
            d.sda_p = sda;
        end else if (start_c) begin
            d.st    = TS_RECV;
            d.ph    = PH_ADDR;
            d.cnt   = '0;
            d.drive = 1'b0;
        end else if (stop_c) begin
            d.st    = TS_IDLE;
            d.drive = 1'b0;
        end else begin
            case (q.st)
                TS_RECV: begin
                    if (rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (fall && q.cnt == 4'd8) begin
                        case (q.ph)
                            PH_ADDR: begin
                                ok_c = (q.sh[7:1] == {DEV_ADDR_HI, addr_pins}) && !q.sh[0];
                                d.ph = PH_SUB;
                            end
                            PH_SUB: begin
                                ok_c = 1'b1;
                                d.ph = PH_DATA;
                                if (q.sh[4:0] == BANK_CODE) begin
                                    d.bank = 1'b1;
                                    d.ptr  = '0;
                                end else begin
                                    d.bank = 1'b0;
                                    d.ptr  = {1'b0, q.sh[3:0]};
                                end
                            end
                            default: begin
                                ok_c = (q.ptr < LAST_PTR);
                                if (ok_c) begin
                                    d.wr.valid = 1'b1;
                                    d.wr.idx   = q.ptr;
                                    d.wr.data  = q.sh;
                                    if (q.bank) d.ptr = q.ptr + 1'b1;
                                    else        d.ph  = PH_SUB;
                                end
                            end
                        endcase
                        d.drive = ok_c;
                        d.st    = TS_ACK;
                    end
                end
                TS_ACK: begin
                    if (fall) begin
                        d.st    = q.drive ? TS_RECV : TS_IDLE;
                        d.drive = 1'b0;
                        d.cnt   = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign sda_oe = q.drive;
    assign wr_o   = q.wr;
endmodule

// File: rtl/cfg_3w_tgt.sv
`timescale 1ns/1ps
module cfg_3w_tgt
    import cfg_bank_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    sen,
    input  logic    sclk,
    input  logic    sdat,
    output wr_req_t wr_o
);
    localparam int CNT_SAT = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    typedef struct packed {
        logic                  sen_p;
        logic                  sclk_p;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
        wr_req_t               wr;
    } tw_q_t;

    localparam tw_q_t RST = '{sen_p: 1'b1, sclk_p: 1'b0, cnt: '0, sh: '0, wr: '0};

    tw_q_t d, q;

    always_comb begin
        d        = q;
        d.wr     = '0;
        d.sen_p  = sen;
        d.sclk_p = sclk;
        if (!en) begin
            d        = RST;
            d.sen_p  = sen;
            d.sclk_p = sclk;
        end else begin
            if (!sen && q.sen_p) begin
                d.cnt = '0;
            end else if (!sen && sclk && !q.sclk_p) begin
                d.sh = {q.sh[FRAME_BITS-2:0], sdat};
                if (q.cnt != CNT_W'(CNT_SAT)) d.cnt = q.cnt + 1'b1;
            end
            if (sen && !q.sen_p && q.cnt == CNT_W'(FRAME_BITS)) begin
                d.wr.valid = 1'b1;
                d.wr.idx   = {1'b0, q.sh[FRAME_BITS-5 -: SUB_IDX_W]};
                d.wr.data  = q.sh[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign wr_o = q.wr;
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
    import cfg_bank_pkg::*;
#(
    parameter int NUM_REGS = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  wr_req_t                   wr_i,
    input  logic                      blk,
    output logic [NUM_REGS-1:0][7:0]  regs_o,
    output logic [NUM_REGS-1:0]       stb_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
        logic [NUM_REGS-1:0]      stb;
    } rf_q_t;

    function automatic rf_q_t rf_reset();
        rf_q_t r;
        r.stb = '0;
        for (int k = 0; k < NUM_REGS; k++) r.regs[k] = reg_default(k);
        return r;
    endfunction

    rf_q_t d, q;

    always_comb begin
        d     = q;
        d.stb = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (wr_i.valid && !blk && wr_i.idx == PTR_W'(k)) begin
                d.regs[k] = wr_i.data;
                d.stb[k]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rf_reset();
        else        q <= d;
    end

    assign regs_o = q.regs;
    assign stb_o  = q.stb;
endmodule

// File: rtl/serial_cfg_bank.sv
`timescale 1ns/1ps
module serial_cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int NUM_REGS    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  if_sel,
    input  logic                  upd_block,
    input  logic [1:0]            addr_pins,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic                  sen_i,
    input  logic                  sclk_i,
    input  logic                  sdat_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_stb_o
);
    localparam int         N_IN     = 5;
    localparam logic [4:0] IN_IDLE  = 5'b11100;

    logic [N_IN-1:0] raw_in, flt_in;
    logic            scl_f, sda_f, sen_f, sclk_f, sdat_f;
    wr_req_t         i2c_req, tw_req, sel_req;
    logic [NUM_REGS-1:0][7:0] bank;

    assign raw_in = {scl_i, sda_i, sen_i, sclk_i, sdat_i};
    assign {scl_f, sda_f, sen_f, sclk_f, sdat_f} = flt_in;

    cfg_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(flt_in)
    );

    cfg_i2c_tgt #(.NUM_REGS(NUM_REGS)) i2c_i (
        .clk(clk), .rst_n(rst_n), .en(!if_sel), .addr_pins(addr_pins),
        .scl(scl_f), .sda(sda_f), .sda_oe(sda_oe), .wr_o(i2c_req)
    );

    cfg_3w_tgt #(.FRAME_BITS(16)) tw_i (
        .clk(clk), .rst_n(rst_n), .en(if_sel), .sen(sen_f),
        .sclk(sclk_f), .sdat(sdat_f), .wr_o(tw_req)
    );

    assign sel_req = if_sel ? tw_req : i2c_req;

    cfg_reg_file #(.NUM_REGS(NUM_REGS)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_i(sel_req), .blk(upd_block),
        .regs_o(bank), .stb_o(wr_stb_o)
    );

    assign regs_o = bank;
endmodule

// File: rtl/serial_cfg_bank_chk.sv
`timescale 1ns/1ps
module serial_cfg_bank_chk #(
    parameter int NUM_REGS = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  if_sel,
    input logic                  upd_block,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs_o,
    input logic [NUM_REGS-1:0]   wr_stb_o
);
    // R10: never two strobes together
    a_r10_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));

    // R9: blocked cycle produces no strobe on the following edge
    a_r9_no_stb_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        upd_block |=> (wr_stb_o == '0));

    // R8: three-wire selection keeps the acknowledge drive off
    a_r8_no_ack_in_3w: assert property (@(posedge clk) disable iff (!rst_n)
        if_sel |=> !sda_oe);

    // R10: a register without its strobe holds its value
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hold
        a_r10_hold_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb_o[k] |-> $stable(regs_o[k*8 +: 8]));
    end
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .upd_block(upd_block),
    .sda_oe(sda_oe), .regs_o(regs_o), .wr_stb_o(wr_stb_o)
);

// File: tb/serial_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_bank_tb_top;
    localparam int NR = 14;
    localparam int QP = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, if_sel, upd_block, scl_drv, sda_drv, sen, sclk, sdat, sda_oe;
    logic [1:0]      addr_pins;
    logic [NR*8-1:0] regs_o;
    logic [NR-1:0]   wr_stb_o;
    wire             sda_line = sda_drv & ~sda_oe;

    serial_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .upd_block(upd_block),
        .addr_pins(addr_pins), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .sen_i(sen), .sclk_i(sclk), .sdat_i(sdat), .regs_o(regs_o), .wr_stb_o(wr_stb_o)
    );

    int         checks = 0;
    int         failures = 0;
    logic [7:0] exp_r [NR];
    int         stb_cnt [NR];
    int         stb_snap [NR];

    always @(negedge clk)
        for (int k = 0; k < NR; k++) if (wr_stb_o[k] === 1'b1) stb_cnt[k]++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NR; k++)
            chk_eq(req, $sformatf("reg%0d", k), int'(regs_o[k*8 +: 8]), int'(exp_r[k]));
    endtask

    task automatic snap_stb();
        for (int k = 0; k < NR; k++) stb_snap[k] = stb_cnt[k];
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; scl_drv = 1'b1; tick(2*QP);
        sda_drv = 1'b0; tick(2*QP);
        scl_drv = 1'b0; tick(QP);
    endtask

    task automatic i2c_stop();
        tick(QP); sda_drv = 1'b0; tick(QP);
        scl_drv = 1'b1; tick(2*QP);
        sda_drv = 1'b1; tick(2*QP);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tick(QP); sda_drv = b[i]; tick(QP);
            scl_drv = 1'b1; tick(2*QP);
            scl_drv = 1'b0;
        end
        tick(QP); sda_drv = 1'b1; tick(QP);
        scl_drv = 1'b1; tick(QP);
        acked = (sda_line == 1'b0);
        tick(QP); scl_drv = 1'b0;
    endtask

    task automatic tw_frame(input logic [16:0] bits, input int n);
        sen = 1'b0; tick(2*QP);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = bits[i]; tick(QP);
            sclk = 1'b1; tick(QP);
            sclk = 1'b0;
        end
        tick(QP); sen = 1'b1; tick(4*QP);
    endtask

    localparam logic [7:0] ADDR_OK = {5'b10011, 2'b01, 1'b0};

    initial begin
        repeat (180000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit a;
        rst_n = 1'b0; if_sel = 1'b0; upd_block = 1'b0; addr_pins = 2'b00;
        scl_drv = 1'b1; sda_drv = 1'b1; sen = 1'b1; sclk = 1'b0; sdat = 1'b0;
        for (int k = 0; k < NR; k++) begin exp_r[k] = 8'(k*16 + 5); stb_cnt[k] = 0; end
        tick(5); rst_n = 1'b1; tick(5);

        // R1 reset state
        check_regs("R1");
        chk_eq("R1", "wr_stb_o", int'(wr_stb_o), 0);
        chk_eq("R1", "sda_oe", int'(sda_oe), 0);

        // R2 address sweep over every pin setting, compared bits and R/W
        for (int p = 0; p < 4; p++) begin
            addr_pins = 2'(p);
            for (int c = 0; c < 8; c++) begin
                bit         want;
                int         k;
                logic [7:0] dv;
                want = (c[2:1] == p[1:0]) && (c[0] == 1'b0);
                k    = (p*8 + c) % NR;
                dv   = 8'(p*8 + c + 100);
                i2c_start();
                i2c_byte({5'b10011, 3'(c)}, a);
                chk_eq("R2", $sformatf("addr ack pins=%0d c=%0d", p, c), int'(a), int'(want));
                i2c_byte(8'(k), a);
                i2c_byte(dv, a);
                i2c_stop();
                if (want) exp_r[k] = dv;
            end
        end
        check_regs("R2");
        addr_pins = 2'b01;

        // R3 single mode, alternating subaddress and data, junk in bits 7..5
        i2c_start();
        i2c_byte(ADDR_OK, a); chk_eq("R3", "addr ack", int'(a), 1);
        for (int k = 0; k < NR; k++) begin
            i2c_byte(8'h40 | 8'(k), a); chk_eq("R3", "sub ack", int'(a), 1);
            i2c_byte(8'(k*37 + 11), a); chk_eq("R3", "data ack", int'(a), 1);
            exp_r[k] = 8'(k*37 + 11);
        end
        i2c_stop();
        check_regs("R3");

        // R6 single mode to nonexistent registers 14 and 15
        for (int s = NR; s < 16; s++) begin
            i2c_start();
            i2c_byte(ADDR_OK, a);
            i2c_byte(8'(s), a); chk_eq("R6", "sub ack", int'(a), 1);
            i2c_byte(8'hEE, a); chk_eq("R6", "data nack", int'(a), 0);
            i2c_stop();
        end
        check_regs("R6");

        // R4 / R5 / R10 bank mode with one byte past the end
        snap_stb();
        i2c_start();
        i2c_byte(ADDR_OK, a);
        i2c_byte(8'hBF, a); chk_eq("R4", "bank sub ack", int'(a), 1);
        for (int k = 0; k < NR; k++) begin
            i2c_byte(8'(k*53 + 7), a); chk_eq("R4", $sformatf("bank data ack %0d", k), int'(a), 1);
            exp_r[k] = 8'(k*53 + 7);
        end
        i2c_byte(8'h99, a); chk_eq("R5", "overflow nack", int'(a), 0);
        i2c_stop();
        check_regs("R4");
        for (int k = 0; k < NR; k++)
            chk_eq("R10", $sformatf("strobes reg%0d", k), stb_cnt[k] - stb_snap[k], 1);

        // R4 mode bit with a normal low nibble stays single
        i2c_start();
        i2c_byte(ADDR_OK, a);
        i2c_byte(8'h13, a); i2c_byte(8'h5A, a);
        i2c_byte(8'h04, a); i2c_byte(8'hC3, a);
        chk_eq("R4", "second single ack", int'(a), 1);
        i2c_stop();
        exp_r[3] = 8'h5A; exp_r[4] = 8'hC3;
        check_regs("R4");

        // R7 three-wire frames, upper address nibble is don't-care
        if_sel = 1'b1; tick(QP);
        for (int k = 0; k < NR; k++) begin
            tw_frame({1'b0, 4'h6, 4'(k), 8'(k*29 + 1)}, 16);
            exp_r[k] = 8'(k*29 + 1);
        end
        check_regs("R7");
        tw_frame({1'b0, 8'h02, 8'hAB} >> 1, 15);
        tw_frame({8'h02, 8'hAB, 1'b1}, 17);
        tw_frame({1'b0, 8'h0E, 8'hAB}, 16);
        check_regs("R7");

        // R8 traffic on the deselected interface
        i2c_start();
        i2c_byte(ADDR_OK, a); chk_eq("R8", "no ack while 3-wire", int'(a), 0);
        i2c_byte(8'h05, a); i2c_byte(8'h00, a);
        i2c_stop();
        if_sel = 1'b0; tick(QP);
        tw_frame({1'b0, 8'h06, 8'h00}, 16);
        check_regs("R8");

        // R9 blocked updates on both interfaces
        snap_stb();
        upd_block = 1'b1;
        i2c_start();
        i2c_byte(ADDR_OK, a); i2c_byte(8'h07, a); i2c_byte(8'h00, a);
        i2c_stop();
        if_sel = 1'b1; tick(QP);
        tw_frame({1'b0, 8'h08, 8'h00}, 16);
        check_regs("R9");
        for (int k = 0; k < NR; k++)
            chk_eq("R9", $sformatf("no strobe reg%0d", k), stb_cnt[k] - stb_snap[k], 0);

        // R10 recovery after unblock: one strobe, new value
        upd_block = 1'b0; tick(QP);
        tw_frame({1'b0, 8'h08, 8'h3C}, 16);
        exp_r[8] = 8'h3C;
        check_regs("R10");
        chk_eq("R10", "strobe reg8 after unblock", stb_cnt[8] - stb_snap[8], 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule